// File: doc/BRIEF.md
# Composite Sync and Blanking Timing Generator

This block produces the line and field timing strobes for a digital NTSC/PAL video encoder clocked at 13.5 MHz. A horizontal cycle counter steps through each line and a line counter steps through the frame. From these two counts, combinational decode logic produces several outputs for a downstream level adder:

- a composite sync level select, which carries normal horizontal sync, equalizing pulses or serrated broad pulses depending on the line;
- a horizontal blanking flag;
- a colour burst gate;
- a vertical sync flag, together with a one-cycle strobe on its falling edge. Register-update logic can use this strobe to load new settings.

A standard-select input chooses NTSC or PAL timing. The choice is sampled only at reset and at the frame boundary, so a frame never mixes the two standards. The current cycle and line counts are also exported for downstream use. Line counts per frame are parameters. Their defaults are 525 lines for NTSC and 625 for PAL.

Top module: `csync_gen`

## Requirements
- R1: `hcount` counts 0 up to 857 (NTSC, `pal_sel` latched 0) or 863 (PAL, latched 1), then returns to 0 on the next cycle.
- R2: `line_num` advances by one each time `hcount` wraps. After line LINES_NTSC-1 (NTSC) or LINES_PAL-1 (PAL) it returns to 0, which is the frame start.
- R3: On lines outside the vertical interval, `csync` is 1 exactly while `hcount` < 63.
- R4: `burst_gate` is 1 exactly while 72 <= `hcount` < 106 in NTSC, or 76 <= `hcount` < 107 in PAL, on every line.
- R5: `hblank` is 1 exactly while `hcount` < 127 or `hcount` >= 837 in NTSC, or while `hcount` < 142 or `hcount` >= 844 in PAL.
- R6: Some half-lines carry equalizing pulses, where `csync` is 1 for the first 31 (NTSC) or 32 (PAL) cycles of the half-line. Half-lines start at `hcount` 0 and at 429 (NTSC) or 432 (PAL). NTSC lines 0-2 and 6-8 are equalizing on both halves. PAL lines 0, 1, 5 and 6 are equalizing on both halves, and lines 2 and 7 are equalizing on their first half only. The second half of PAL line 7 carries no sync.
- R7: Some half-lines are serrated, where `csync` is 1 except in the last cycles of each half-line. The serration cycles are 366-428 and 795-857 in NTSC, and 368-431 and 800-863 in PAL. NTSC lines 3-5 are serrated. In PAL the second half of line 2 and all of lines 3-4 are serrated.
- R8: `vsync` is 1 exactly during serrated half-lines. `vsync_fall` is 1 for only the first cycle on which `vsync` is 0 after a cycle with `vsync` at 1.
- R9: A cycle with `rst_n` low sets both counters to 0 on the next clock and latches `pal_sel`. Otherwise `pal_sel` is latched only on the last cycle of a frame. A change of `pal_sel` within a frame leaves the line length unchanged until the next frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 13.5 MHz pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pal_sel | input | 1 | Standard request: 0 NTSC, 1 PAL |
| hcount | output | 10 | Cycle position within the line |
| line_num | output | LINE_W | Line index within the frame |
| csync | output | 1 | Sync level select for the adder |
| hblank | output | 1 | Horizontal blanking flag |
| burst_gate | output | 1 | Colour burst window |
| vsync | output | 1 | High during serrated half-lines |
| vsync_fall | output | 1 | One-cycle strobe on the falling edge of vsync |

## Verification
The counters are registers and every strobe is decoded from them without further delay. This means `csync`, `hblank`, `burst_gate` and `vsync` are checked in the same cycle against the count the bench expects. The only exception is `vsync_fall`, which depends on the previous cycle's `vsync` through one register. A reset or a `pal_sel` value applied before a clock edge shows up in the counts right after that edge. A latched standard change becomes visible as the new line length starting from the first frame after the change. The bench keeps its own model of both counters and the latched standard, advances the model on each edge, and compares every output at the falling clock edge.

// File: rtl/csync_pkg.sv
// Shared constants and types for the composite sync generator.
// All positions are 13.5 MHz cycle counts within a line; ranges are half-open.
package csync_pkg;
    localparam int HCNT_W = 10;

    typedef logic [HCNT_W-1:0] hcnt_t;

    // Line lengths
    localparam hcnt_t N_LEN  = hcnt_t'(858);
    localparam hcnt_t P_LEN  = hcnt_t'(864);
    // Half-line point
    localparam hcnt_t N_HALF = hcnt_t'(429);
    localparam hcnt_t P_HALF = hcnt_t'(432);
    // Normal horizontal sync end (same in both standards)
    localparam hcnt_t HS_END = hcnt_t'(63);
    // Equalizing pulse width
    localparam hcnt_t N_EQW  = hcnt_t'(31);
    localparam hcnt_t P_EQW  = hcnt_t'(32);
    // Broad pulse width within a half-line (serration follows)
    localparam hcnt_t N_BRW  = hcnt_t'(366);
    localparam hcnt_t P_BRW  = hcnt_t'(368);
    // Burst window
    localparam hcnt_t N_BST  = hcnt_t'(72);
    localparam hcnt_t N_BEN  = hcnt_t'(106);
    localparam hcnt_t P_BST  = hcnt_t'(76);
    localparam hcnt_t P_BEN  = hcnt_t'(107);
    // Blanking edges
    localparam hcnt_t N_BLE  = hcnt_t'(127);
    localparam hcnt_t N_BLS  = hcnt_t'(837);
    localparam hcnt_t P_BLE  = hcnt_t'(142);
    localparam hcnt_t P_BLS  = hcnt_t'(844);

    // What a half-line carries on the sync output
    typedef enum logic [1:0] {
        PK_NORMAL = 2'd0,
        PK_EQ     = 2'd1,
        PK_BROAD  = 2'd2,
        PK_NONE   = 2'd3
    } pulse_kind_t;
endpackage

// File: rtl/csync_hcount.sv
// Horizontal cycle counter. Counts one line of the latched standard and
// flags its last cycle. Assumes pal_mode changes only at a line wrap.
module csync_hcount
    import csync_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  pal_mode,
    output hcnt_t hcount,
    output logic  line_last
);
    hcnt_t line_len;

    // Select the line length of the latched standard
    always_comb begin
        line_len  = pal_mode ? P_LEN : N_LEN;
        line_last = (hcount == line_len - hcnt_t'(1));
    end

    // Advance the cycle count and wrap at the end of the line
    always_ff @(posedge clk) begin
        if (!rst_n)         hcount <= '0;
        else if (line_last) hcount <= '0;
        else                hcount <= hcount + hcnt_t'(1);
    end

    AST_H_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        hcount < line_len);                                             // R1
    AST_H_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        line_last |=> (hcount == '0));                                  // R1
endmodule

// File: rtl/csync_linecount.sv
// Line counter and standard latch. Steps once per line wrap, wraps at the
// frame length, and takes a new standard only at reset or frame end.
module csync_linecount #(
    parameter int LINES_NTSC = 525,
    parameter int LINES_PAL  = 625,
    parameter int LINE_W     = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pal_sel,
    input  logic              line_last,
    output logic [LINE_W-1:0] line_num,
    output logic              pal_mode,
    output logic              frame_last
);
    logic [LINE_W-1:0] last_line;

    // Last line index of the latched standard and the frame-end flag
    always_comb begin
        last_line  = pal_mode ? LINE_W'(LINES_PAL - 1) : LINE_W'(LINES_NTSC - 1);
        frame_last = line_last && (line_num == last_line);
    end

    // Count lines, wrap at frame end and latch the standard there
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_num <= '0;
            pal_mode <= pal_sel;
        end else if (frame_last) begin
            line_num <= '0;
            pal_mode <= pal_sel;
        end else if (line_last) begin
            line_num <= line_num + LINE_W'(1);
        end
    end

    AST_LINE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        line_num <= last_line);                                         // R2
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_last |=> $stable(pal_mode));                             // R9
endmodule

// File: rtl/csync_decode.sv
// Timing decoder. Turns cycle and line counts into sync, blanking, burst
// and vertical flags. Assumes counts are in range for the given standard.
module csync_decode
    import csync_pkg::*;
#(
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pal_mode,
    input  hcnt_t             hcount,
    input  logic [LINE_W-1:0] line_num,
    output logic              csync,
    output logic              hblank,
    output logic              burst_gate,
    output logic              vsync,
    output logic              vsync_fall
);
    hcnt_t       half_pt, eq_w, br_w, hh;
    logic        second;
    logic [31:0] ln;
    pulse_kind_t kind;
    logic        vsync_q;

    // Standard-dependent pulse geometry and the position within the half-line
    always_comb begin
        half_pt = pal_mode ? P_HALF : N_HALF;
        eq_w    = pal_mode ? P_EQW  : N_EQW;
        br_w    = pal_mode ? P_BRW  : N_BRW;
        second  = (hcount >= half_pt);
        hh      = second ? (hcount - half_pt) : hcount;
        ln      = 32'(line_num);
    end

    // Classify the current half-line by its position in the vertical interval
    always_comb begin
        kind = PK_NORMAL;
        if (pal_mode) begin
            case (ln)
                32'd0, 32'd1, 32'd5, 32'd6: kind = PK_EQ;
                32'd2:                      kind = second ? PK_BROAD : PK_EQ;
                32'd3, 32'd4:               kind = PK_BROAD;
                32'd7:                      kind = second ? PK_NONE : PK_EQ;
                default:                    kind = PK_NORMAL;
            endcase
        end else begin
            if (ln < 32'd3)       kind = PK_EQ;
            else if (ln < 32'd6)  kind = PK_BROAD;
            else if (ln < 32'd9)  kind = PK_EQ;
            else                  kind = PK_NORMAL;
        end
    end

    // Sync level select for the half-line kind
    always_comb begin
        case (kind)
            PK_NORMAL: csync = !second && (hh < HS_END);
            PK_EQ:     csync = (hh < eq_w);
            PK_BROAD:  csync = (hh < br_w);
            default:   csync = 1'b0;
        endcase
    end

    // Horizontal blanking and burst windows
    always_comb begin
        if (pal_mode) begin
            hblank     = (hcount < P_BLE) || (hcount >= P_BLS);
            burst_gate = (hcount >= P_BST) && (hcount < P_BEN);
        end else begin
            hblank     = (hcount < N_BLE) || (hcount >= N_BLS);
            burst_gate = (hcount >= N_BST) && (hcount < N_BEN);
        end
        vsync      = (kind == PK_BROAD);
        vsync_fall = vsync_q && !vsync;
    end

    // Remember the previous vertical flag for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) vsync_q <= 1'b0;
        else        vsync_q <= vsync;
    end

    AST_BURST_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        burst_gate |-> hblank);                                         // R4
    AST_SYNC_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (csync && !vsync) |-> (hblank || (hh < eq_w)));                 // R6
    AST_VSF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_fall |=> !vsync_fall);                                    // R8
    AST_VSF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_fall |-> !vsync);                                         // R8
endmodule

// File: rtl/csync_gen.sv
// Composite sync and blanking generator, top level. Joins the cycle
// counter, line counter and decoder. Assumes a 13.5 MHz clock.
module csync_gen
    import csync_pkg::*;
#(
    parameter int LINES_NTSC = 525,
    parameter int LINES_PAL  = 625,
    localparam int LINES_MAX = (LINES_PAL > LINES_NTSC) ? LINES_PAL : LINES_NTSC,
    localparam int LINE_W    = $clog2(LINES_MAX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pal_sel,
    output logic [9:0]        hcount,
    output logic [LINE_W-1:0] line_num,
    output logic              csync,
    output logic              hblank,
    output logic              burst_gate,
    output logic              vsync,
    output logic              vsync_fall
);
    logic pal_mode, line_last, frame_last;

    csync_hcount u_hcount (
        .clk       (clk),
        .rst_n     (rst_n),
        .pal_mode  (pal_mode),
        .hcount    (hcount),
        .line_last (line_last)
    );

    csync_linecount #(
        .LINES_NTSC (LINES_NTSC),
        .LINES_PAL  (LINES_PAL),
        .LINE_W     (LINE_W)
    ) u_linecount (
        .clk        (clk),
        .rst_n      (rst_n),
        .pal_sel    (pal_sel),
        .line_last  (line_last),
        .line_num   (line_num),
        .pal_mode   (pal_mode),
        .frame_last (frame_last)
    );

    csync_decode #(
        .LINE_W (LINE_W)
    ) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .pal_mode   (pal_mode),
        .hcount     (hcount),
        .line_num   (line_num),
        .csync      (csync),
        .hblank     (hblank),
        .burst_gate (burst_gate),
        .vsync      (vsync),
        .vsync_fall (vsync_fall)
    );

    AST_WRAP_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (line_last && !frame_last) |=> (hcount == '0));                 // R2
endmodule

// File: tb/csync_gen_tb.sv
// Bench for csync_gen: reference counter model plus random standard
// switching and resets, all outputs compared at the falling clock edge.
module csync_gen_tb;
    localparam int LN = 12;
    localparam int LP = 15;
    localparam int LW = $clog2(LP);
    localparam int CYCLES = 120000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pal_sel = 1'b0;
    logic [9:0]    hcount;
    logic [LW-1:0] line_num;
    logic          csync, hblank, burst_gate, vsync, vsync_fall;

    int  tests = 0;
    int  fails = 0;
    bit  done = 1'b0;
    int  mh, ml, mm;
    bit  vq;
    int  rst_hold = 0;

    always #5 clk = ~clk;

    csync_gen #(.LINES_NTSC(LN), .LINES_PAL(LP)) u_dut (
        .clk(clk), .rst_n(rst_n), .pal_sel(pal_sel),
        .hcount(hcount), .line_num(line_num), .csync(csync),
        .hblank(hblank), .burst_gate(burst_gate),
        .vsync(vsync), .vsync_fall(vsync_fall)
    );

    function automatic int f_len(int m);   return m ? 864 : 858; endfunction
    function automatic int f_lines(int m); return m ? LP : LN;   endfunction

    // Half-line class: 0 normal, 1 equalizing, 2 serrated, 3 empty
    function automatic int f_class(int m, int l, int h);
        bit sec = m ? (h >= 432) : (h >= 429);
        if (!m) begin
            if (l >= 3 && l <= 5) return 2;
            if (l <= 8)           return 1;
            return 0;
        end
        if (l == 3 || l == 4)     return 2;
        if (l == 2)               return sec ? 2 : 1;
        if (l == 7)               return sec ? 3 : 1;
        if (l <= 6)               return 1;
        return 0;
    endfunction

    function automatic bit f_sync(int m, int l, int h);
        int c = f_class(m, l, h);
        if (c == 0) return h < 63;
        if (c == 3) return 1'b0;
        if (c == 1) return m ? (h < 32 || (h >= 432 && h < 464))
                             : (h < 31 || (h >= 429 && h < 460));
        return m ? !((h >= 368 && h < 432) || h >= 800)
                 : !((h >= 366 && h < 429) || h >= 795);
    endfunction

    function automatic bit f_blank(int m, int h);
        return m ? (h < 142 || h >= 844) : (h < 127 || h >= 837);
    endfunction

    function automatic bit f_burst(int m, int h);
        return m ? (h >= 76 && h < 107) : (h >= 72 && h < 106);
    endfunction

    task automatic chk(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (model h=%0d line=%0d pal=%0d)",
                     tag, act, exp, mh, ml, mm);
        end
    endtask

    task automatic check_all();
        int c = f_class(mm, ml, mh);
        bit vs = (c == 2);
        chk((pal_sel != mm[0]) ? "R9 hcount" : "R1 hcount", int'(hcount), mh);
        chk("R2 line_num", int'(line_num), ml);
        chk((c == 0) ? "R3 csync" : (c == 2) ? "R7 csync" : "R6 csync",
            int'(csync), int'(f_sync(mm, ml, mh)));
        chk("R5 hblank", int'(hblank), int'(f_blank(mm, mh)));
        chk("R4 burst_gate", int'(burst_gate), int'(f_burst(mm, mh)));
        chk("R8 vsync", int'(vsync), int'(vs));
        chk("R8 vsync_fall", int'(vsync_fall), int'(vq && !vs));
    endtask

    // Advance the reference model over one clock edge
    task automatic model_step();
        if (!rst_n) begin
            mh = 0; ml = 0; mm = int'(pal_sel); vq = 1'b0;
        end else begin
            vq = (f_class(mm, ml, mh) == 2);
            if (mh == f_len(mm) - 1) begin
                mh = 0;
                if (ml == f_lines(mm) - 1) begin
                    ml = 0; mm = int'(pal_sel);
                end else ml++;
            end else mh++;
        end
    endtask

    initial begin
        void'($urandom(32'h1d5a_0c37));
        rst_n = 1'b0; pal_sel = 1'b0;
        repeat (3) @(posedge clk);
        mh = 0; ml = 0; mm = 0; vq = 1'b0;
        @(negedge clk);
        chk("R9 reset hcount", int'(hcount), 0);
        chk("R9 reset line", int'(line_num), 0);
        rst_n = 1'b1;
        model_step();
        for (int cyc = 0; cyc < CYCLES; cyc++) begin
            @(negedge clk);
            check_all();
            // Directed: switch standard mid-frame early on
            if (cyc == 3000) pal_sel = 1'b1;
            else if (cyc > 30000 && ($urandom % 4000) == 0) pal_sel = ~pal_sel;
            if (rst_hold > 0) begin
                rst_hold--;
                rst_n = (rst_hold == 0);
            end else if (cyc > 50000 && ($urandom % 30000) == 0) begin
                rst_hold = 1 + ($urandom % 3);
                rst_n = 1'b0;
            end
            model_step();
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        done = 1'b1;
        $finish;
    end

    initial begin
        #((CYCLES + 1000) * 10);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule